// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits beside a CPU core and decides when, and to where, control leaves the running program. Four sources compete for it: a free-running tick timer, a fault detector, an external device chain, and the software trap instruction with its 8-bit vector. At an instruction boundary the controller picks the most urgent pending source. It clears the interrupt enable and, for an external device, fetches a full 16-bit handler address through a one-cycle acknowledge handshake. It then saves PC and flags on the stack and loads the new PC with an end-of-interrupt strobe.

Internal sources are vectored: the handler address is read from a low memory word whose index is the vector. On a return request the controller pops flags, then PC, and then drives a service-end strobe low for half a clock so the device chain can close again. Stack and memory traffic go through one request/acknowledge port, and the CPU supplies the current PC and flags.

Top module: `irq_dispatch`

## Requirements
- R1: With the timer enabled, a timer request becomes pending once every `tick_limit`+1 clock cycles; a request that arrives while the controller is busy stays pending until it is serviced, so consecutive timer services are exactly `tick_limit`+1 cycles apart.
- R2: When several sources are pending at one boundary, they are served in the order timer, fault, external device, software trap.
- R3: For an external request, `ext_iak` is high for exactly one cycle, `ext_addr` is captured during that cycle, and that value is the PC loaded at end of interrupt.
- R4: An external request is ignored while `ie` is 0, and the controller then waits for `ext_irq` to fall before it touches the stack.
- R5: `ie` is 0 after reset, is set by `ei_set`, cleared by `di_set`, and cleared by every dispatch.
- R6: Timer and fault requests are served while `ie` is 0.
- R7: A dispatch pushes the current PC first and the flags second (`bus_op` 1 = push), and the request with its address and operation stays unchanged until `bus_ack`.
- R8: Internal sources read their handler from word address = vector (`bus_op` 0 = read): timer 0, fault 1, software trap its 8-bit vector; the word read is the PC loaded with `eoi`.
- R9: With `con_fault_halt` set, a fault raises `halt` instead of trapping; `halt` holds until reset and no further dispatch occurs.
- R10: With `con_timer_off` set, no timer request is produced and any pending one is dropped.
- R11: `reti_req` pops flags then PC (`bus_op` 2 = pop), loading each, and in the next cycle `ise_n` is low during the high half of the clock only; `ise_n` is high after reset.
- R12: No source is dispatched while `instr_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_done | input | 1 | CPU is at an instruction boundary |
| ei_set | input | 1 | Enable external interrupts |
| di_set | input | 1 | Disable external interrupts |
| sw_int_req | input | 1 | Software trap request pulse |
| sw_int_vec | input | VW | Software trap vector |
| fault_req | input | 1 | Fault detected pulse |
| con_timer_off | input | 1 | Console: timer disabled |
| con_fault_halt | input | 1 | Console: halt on fault |
| tick_limit | input | TW | Timer terminal count |
| ext_irq | input | 1 | External device request |
| ext_addr | input | W | Handler address driven by device |
| ext_iak | output | 1 | External acknowledge |
| reti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | W | Current PC |
| flags_in | input | W | Current flags |
| bus_req | output | 1 | Memory/stack request |
| bus_op | output | 2 | 0 read, 1 push, 2 pop |
| bus_addr | output | W | Read address |
| bus_wdata | output | W | Push data |
| bus_rdata | input | W | Read/pop data |
| bus_ack | input | 1 | Request completed |
| pc_load | output | 1 | Load PC strobe |
| pc_value | output | W | New PC |
| flags_load | output | 1 | Load flags strobe |
| flags_value | output | W | Restored flags |
| eoi | output | 1 | End of interrupt strobe |
| ise_n | output | 1 | Service-end strobe, active low, half clock |
| ie | output | 1 | Interrupt enable state |
| halt | output | 1 | Halted on fault |

## Verification
The hardest situation to reach is all four sources pending at the same boundary, because the timer only fires on its own schedule and every dispatch clears the enable that the external device needs. The stimulus holds `instr_done` low and raises the fault, trap and device requests, then lets the timer expire. On release, the bench re-enables interrupts after each end-of-interrupt, as a handler would, so the full service order becomes visible in the loaded PCs. Randomized trap vectors and PC/flag values exercise vector lookup and the stack round trip.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int W  = 16,
  parameter int VW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          ei_set,
  input  logic          di_set,
  input  logic          sw_int_req,
  input  logic [VW-1:0] sw_int_vec,
  input  logic          fault_req,
  input  logic          con_timer_off,
  input  logic          con_fault_halt,
  input  logic [TW-1:0] tick_limit,
  input  logic          ext_irq,
  input  logic [W-1:0]  ext_addr,
  output logic          ext_iak,
  input  logic          reti_req,
  input  logic [W-1:0]  pc_in,
  input  logic [W-1:0]  flags_in,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [W-1:0]  bus_addr,
  output logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  bus_rdata,
  input  logic          bus_ack,
  output logic          pc_load,
  output logic [W-1:0]  pc_value,
  output logic          flags_load,
  output logic [W-1:0]  flags_value,
  output logic          eoi,
  output logic          ise_n,
  output logic          ie,
  output logic          halt
);
  typedef enum logic [3:0] {
    S_IDLE, S_IAK, S_REL, S_PPC, S_PFL, S_VRD, S_LOAD, S_OFL, S_OPC, S_ISE
  } st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic          tmr_p, flt_p, sw_p, ext_sel;
  logic [VW-1:0] sw_v, vec;
  logic [W-1:0]  opr;

  wire tick     = ~con_timer_off & (cnt >= tick_limit);
  wire boundary = (st == S_IDLE) & instr_done & ~halt & ~reti_req;
  wire take_ext = ie & ext_irq;
  wire take     = boundary & (tmr_p | flt_p | take_ext | sw_p);
  wire sel_flt  = ~tmr_p & flt_p;
  wire sel_ext  = ~tmr_p & ~flt_p & take_ext;
  wire sel_sw   = ~tmr_p & ~flt_p & ~take_ext & sw_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tmr_p <= 1'b0;
      flt_p <= 1'b0;
      sw_p  <= 1'b0;
      sw_v  <= '0;
      halt  <= 1'b0;
      ie    <= 1'b0;
    end else begin
      cnt <= (con_timer_off || cnt >= tick_limit) ? '0 : cnt + 1'b1;
      if (con_timer_off)        tmr_p <= 1'b0;
      else if (tick)            tmr_p <= 1'b1;
      else if (take && tmr_p)   tmr_p <= 1'b0;
      if (fault_req && !con_fault_halt) flt_p <= 1'b1;
      else if (take && sel_flt)         flt_p <= 1'b0;
      if (fault_req && con_fault_halt)  halt <= 1'b1;
      if (sw_int_req) begin
        sw_p <= 1'b1;
        sw_v <= sw_int_vec;
      end else if (take && sel_sw) sw_p <= 1'b0;
      if (take)        ie <= 1'b0;
      else if (di_set) ie <= 1'b0;
      else if (ei_set) ie <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vec     <= '0;
      ext_sel <= 1'b0;
      opr     <= '0;
    end else begin
      case (st)
        S_IDLE: if (reti_req && !halt) st <= S_OFL;
                else if (take) begin
                  vec     <= tmr_p ? VW'(0) : flt_p ? VW'(1) : sw_v;
                  ext_sel <= sel_ext;
                  st      <= sel_ext ? S_IAK : S_PPC;
                end
        S_IAK:  begin opr <= ext_addr; st <= S_REL; end
        S_REL:  if (!ext_irq) st <= S_PPC;
        S_PPC:  if (bus_ack) st <= S_PFL;
        S_PFL:  if (bus_ack) st <= ext_sel ? S_LOAD : S_VRD;
        S_VRD:  if (bus_ack) begin opr <= bus_rdata; st <= S_LOAD; end
        S_LOAD: st <= S_IDLE;
        S_OFL:  if (bus_ack) st <= S_OPC;
        S_OPC:  if (bus_ack) st <= S_ISE;
        S_ISE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ext_iak     = (st == S_IAK);
  assign bus_req     = st inside {S_PPC, S_PFL, S_VRD, S_OFL, S_OPC};
  assign bus_op      = (st == S_PPC || st == S_PFL) ? 2'd1 :
                       (st == S_OFL || st == S_OPC) ? 2'd2 : 2'd0;
  assign bus_addr    = {{(W-VW){1'b0}}, vec};
  assign bus_wdata   = (st == S_PPC) ? pc_in : flags_in;
  assign eoi         = (st == S_LOAD);
  assign pc_load     = eoi | ((st == S_OPC) & bus_ack);
  assign pc_value    = eoi ? opr : bus_rdata;
  assign flags_load  = (st == S_OFL) & bus_ack;
  assign flags_value = bus_rdata;
  assign ise_n       = ~((st == S_ISE) & clk);
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         instr_done,
  input logic         ext_iak,
  input logic         ie,
  input logic         halt,
  input logic         bus_req,
  input logic         bus_ack,
  input logic [1:0]   bus_op,
  input logic [W-1:0] bus_addr,
  input logic         ise_n
);
  assert_iak_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_iak |=> !ext_iak);

  assert_iak_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_iak) |-> $past(instr_done));

  assert_iak_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_iak |-> !ie);

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_op)));

  assert_halt_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_iak) |-> !halt);

  assert_ise_quiet_R11: assert property (@(negedge clk) disable iff (!rst_n)
    !ise_n |-> !bus_req);
endmodule

bind irq_dispatch irq_dispatch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ext_iak(ext_iak),
  .ie(ie), .halt(halt), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_op(bus_op), .bus_addr(bus_addr), .ise_n(ise_n)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, VW = 8, TW = 16;

  logic clk = 0, rst_n = 0;
  logic instr_done = 0, ei_tb = 0, ei_auto = 0, di_set = 0;
  logic sw_int_req = 0, fault_req = 0, con_timer_off = 1, con_fault_halt = 0;
  logic [VW-1:0] sw_int_vec = 0;
  logic [TW-1:0] tick_limit = 16'd39;
  logic ext_irq = 0, ext_iak, reti_req = 0;
  logic [W-1:0] ext_addr = 0, pc_in = 0, flags_in = 0;
  logic bus_req, bus_ack = 0, pc_load, flags_load, eoi, ise_n, ie, halt;
  logic [1:0] bus_op;
  logic [W-1:0] bus_addr, bus_wdata, bus_rdata = 0, pc_value, flags_value;
  wire ei_set = ei_tb | ei_auto;

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ei_set(ei_set), .di_set(di_set),
    .sw_int_req(sw_int_req), .sw_int_vec(sw_int_vec), .fault_req(fault_req),
    .con_timer_off(con_timer_off), .con_fault_halt(con_fault_halt), .tick_limit(tick_limit),
    .ext_irq(ext_irq), .ext_addr(ext_addr), .ext_iak(ext_iak), .reti_req(reti_req),
    .pc_in(pc_in), .flags_in(flags_in), .bus_req(bus_req), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .pc_load(pc_load), .pc_value(pc_value), .flags_load(flags_load),
    .flags_value(flags_value), .eoi(eoi), .ise_n(ise_n), .ie(ie), .halt(halt));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [W-1:0] stk [64];
  int sp = 0, nbus = 0;
  logic [W-1:0] push_prev = 0, push_last = 0, last_rd = 0;
  int eoi_n = 0, eoi_time = 0, prev_eoi_time = 0, iak_n = 0;
  logic [W-1:0] eoi_pcs [64];
  logic [W-1:0] fl_val = 0, pop_pc_val = 0;
  int pop_time = 0, ise_hi = 0, ise_lo = 0, ise_time = 0;
  bit auto_en = 0;
  int dev_req_cnt = 0, dev_served = 0;
  bit dev_on = 0, dev_saw = 0;
  logic [W-1:0] dev_addr_tb = 0;

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    memf = (a * 16'd291) ^ 16'h5A00;
  endfunction

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // memory and stack responder
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_ack = 1;
      nbus++;
      case (bus_op)
        2'd1: begin stk[sp] = bus_wdata; sp++; push_prev = push_last; push_last = bus_wdata; end
        2'd2: begin sp--; bus_rdata = stk[sp]; end
        default: begin bus_rdata = memf(bus_addr); last_rd = bus_addr; end
      endcase
    end else bus_ack = 0;
  end

  // external device
  always @(negedge clk) begin
    if (!dev_on && dev_req_cnt != dev_served) begin
      dev_on = 1; ext_irq = 1; ext_addr = dev_addr_tb; dev_served++;
    end else if (dev_on) begin
      if (ext_iak) dev_saw = 1;
      else if (dev_saw) begin ext_irq = 0; dev_on = 0; dev_saw = 0; end
    end
  end

  // monitors
  always @(negedge clk) begin
    #2;
    if (eoi) begin
      if (eoi_n < 64) eoi_pcs[eoi_n] = pc_value;
      eoi_n++;
      prev_eoi_time = eoi_time;
      eoi_time = cyc;
      ei_auto = auto_en;
    end else ei_auto = 0;
    if (ext_iak) iak_n++;
    if (flags_load) fl_val = flags_value;
    if (pc_load && !eoi) begin pop_pc_val = pc_value; pop_time = cyc; end
  end
  always @(posedge clk) begin
    cyc++;
    #1 if (!ise_n) begin ise_hi++; ise_time = cyc; end
  end
  always @(negedge clk) begin
    #1 if (!ise_n) ise_lo++;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wait_eoi(input int n);
    while (eoi_n < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reti();
    @(negedge clk) reti_req = 1;
    @(negedge clk) reti_req = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int n0, nb0, ni0, ih0;
    logic [7:0] v;
    logic [W-1:0] p;
    void'($urandom(32'h1F2E));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ck("R5 reset ie", ie, 0);
    ck("R11 reset ise_n", ise_n, 1);
    ck("R9 reset halt", halt, 0);
    ck("R7 reset bus_req", bus_req, 0);
    ck("R3 reset iak", ext_iak, 0);

    // R4: masked external request
    instr_done = 1; pc_in = 16'h1111; flags_in = 16'h00F0;
    dev_addr_tb = 16'hBEE0; dev_req_cnt++;
    repeat (30) @(negedge clk);
    ck("R4 no iak while ie=0", iak_n, 0);
    ck("R4 no bus while ie=0", nbus, 0);
    ei_tb = 1; @(negedge clk) ei_tb = 0;
    wait_eoi(1);
    ck("R3 iak one cycle", iak_n, 1);
    ck("R3 device address loaded", eoi_pcs[0], 16'hBEE0);
    ck("R4 irq released before push", ext_irq, 0);
    ck("R7 pc pushed first", push_prev, 16'h1111);
    ck("R7 flags pushed second", push_last, 16'h00F0);
    ck("R5 ie cleared by dispatch", ie, 0);

    // R11: return
    do_reti();
    ck("R11 flags restored", fl_val, 16'h00F0);
    ck("R11 pc restored", pop_pc_val, 16'h1111);
    ck("R11 ise low in high phase once", ise_hi, 1);
    ck("R11 ise high in low phase", ise_lo, 0);
    ck("R11 ise follows pc pop", ise_time, pop_time + 1);
    ck("R11 stack empty", sp, 0);

    // R8: random software traps
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom);
      p = 16'($urandom);
      pc_in = p; flags_in = 16'($urandom);
      n0 = eoi_n;
      sw_int_vec = v; sw_int_req = 1;
      @(negedge clk) sw_int_req = 0;
      wait_eoi(n0 + 1);
      ck("R8 vector address", last_rd, {8'h00, v});
      ck("R8 handler loaded", eoi_pcs[n0], memf({8'h00, v}));
      ck("R7 pc pushed", push_prev, p);
      do_reti();
      ck("R11 pc round trip", pop_pc_val, p);
    end

    // R6: fault with ie=0
    n0 = eoi_n;
    ck("R6 ie is off", ie, 0);
    fault_req = 1; @(negedge clk) fault_req = 0;
    wait_eoi(n0 + 1);
    ck("R6 fault served with ie=0", eoi_pcs[n0], memf(16'd1));
    ck("R8 fault vector word", last_rd, 16'd1);
    do_reti();

    // R1 / R6: timer
    n0 = eoi_n;
    con_timer_off = 0;
    wait_eoi(n0 + 2);
    ck("R6 timer handler", eoi_pcs[n0], memf(16'd0));
    ck("R1 timer period", eoi_time - prev_eoi_time, 40);
    con_timer_off = 1;
    repeat (12) @(negedge clk);
    n0 = eoi_n;
    repeat (100) @(negedge clk);
    ck("R10 timer off", eoi_n, n0);
    sp = 0;

    // R2 / R12: all pending at once
    instr_done = 0; auto_en = 1;
    ei_tb = 1; @(negedge clk) ei_tb = 0;
    fault_req = 1; sw_int_req = 1; sw_int_vec = 8'h2C;
    @(negedge clk) begin fault_req = 0; sw_int_req = 0; end
    dev_addr_tb = 16'hC0DE; dev_req_cnt++;
    nb0 = nbus; ni0 = iak_n; n0 = eoi_n;
    tick_limit = 16'd20; con_timer_off = 0;
    repeat (40) @(negedge clk);
    tick_limit = 16'hFFFF;
    ck("R12 no bus off boundary", nbus, nb0);
    ck("R12 no iak off boundary", iak_n, ni0);
    instr_done = 1;
    wait_eoi(n0 + 4);
    ck("R2 first timer", eoi_pcs[n0], memf(16'd0));
    ck("R2 second fault", eoi_pcs[n0+1], memf(16'd1));
    ck("R2 third external", eoi_pcs[n0+2], 16'hC0DE);
    ck("R2 fourth software", eoi_pcs[n0+3], memf(16'h002C));
    con_timer_off = 1; auto_en = 0;
    repeat (5) @(negedge clk);

    // R9: halt on fault
    con_fault_halt = 1;
    fault_req = 1; @(negedge clk) fault_req = 0;
    ck("R9 halt raised", halt, 1);
    nb0 = nbus; n0 = eoi_n; ih0 = iak_n;
    sw_int_vec = 8'h05; sw_int_req = 1; @(negedge clk) sw_int_req = 0;
    repeat (30) @(negedge clk);
    ck("R9 no bus when halted", nbus, nb0);
    ck("R9 no dispatch when halted", eoi_n, n0);
    ck("R9 halt holds", halt, 1);
    ck("R9 no iak when halted", iak_n, ih0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule